// File: doc/BRIEF.md
# Maskable Interrupt Priority Controller

This block keeps one small control register for each maskable interrupt source and decides which pending source, if any, is presented to the processor. Each register sits on a byte-wide register bus. It holds a three-bit priority level and a pending flag. Hardware sets the pending flag with a one-cycle pulse. Software can only clear it.

Every cycle the arbiter looks at all pending sources. A source can win only when the processor's global interrupt enable is high and its level is strictly above the processor priority level input. The highest level wins, and between equal levels the lowest source index wins. The arbiter drives a request line, the index of the winning source and its level. When the processor takes the interrupt it pulses an acknowledge input, and the winning source's pending flag is cleared at that edge.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every register reads 0x00, every level is 0, no flag is pending and `irq_req` is 0.
- R2: A bus write to a source's address stores `bus_wdata[2:0]` as its level. A read returns `{4'b0000, pending, level[2:0]}`, so bits 7..4 always read 0 and writes to them have no effect.
- R3: A write with `bus_wdata[3]`=0 clears that source's pending flag at the clock edge. A write with `bus_wdata[3]`=1 leaves the flag unchanged.
- R4: A pulse on `src_set[i]` sets the pending flag of source i, and the flag is visible from the next cycle.
- R5: When a set pulse falls in the same cycle as a software clear or an acknowledge clear of the same flag, the flag ends up set.
- R6: A source is eligible only when `int_en`=1, its flag is 1 and its level is strictly greater than `cpu_ipl`. A source at level 0 is never eligible.
- R7: Among eligible sources, `irq_id` and `irq_lvl` name the one with the highest level. On a tie the lowest index wins. The outputs follow the registered state combinationally.
- R8: `irq_ack`=1 while `irq_req`=1 clears the pending flag of the source named by `irq_id` at that edge. No other flag is touched.
- R9: Source i is mapped at byte address `SRC_ADDR[i]`. The default map gives indices 0..10 the addresses 0x4D, 0x4E, 0x50, 0x51, 0x52, 0x56, 0x58, 0x59, 0x5A, 0x5B, 0x5C. Unmapped addresses read 0x00, and writes to them change nothing.
- R10: While `irq_req`=0, `irq_id` and `irq_lvl` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| src_set | input | NUM_SRC | Per-source hardware request pulses |
| int_en | input | 1 | Global maskable interrupt enable |
| cpu_ipl | input | 3 | Current processor priority level |
| irq_ack | input | 1 | Processor takes the presented interrupt |
| irq_req | output | 1 | An eligible source exists |
| irq_id | output | ID_W | Index of the winning source |
| irq_lvl | output | 3 | Level of the winning source |

## Verification
Three functions can act on one pending flag in the same cycle: the hardware set pulse, a software write that clears the flag, and the acknowledge clear. The bench drives a set pulse in the very cycle of a clearing write, and again in the very cycle of an acknowledge aimed at the same source. It then reads the register back over the bus and looks at the arbiter outputs in the next cycle, where the flag must still be set. In-RTL properties check that a flag falls only after a clear with no set pulse in that cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LVL_W    = 3;
  localparam int DATA_W   = 8;
  localparam int FLAG_BIT = 3;

  typedef logic [LVL_W-1:0] lvl_t;

  // a source may be offered to the processor only under all three gates
  function automatic logic is_eligible(logic ien, logic pend, lvl_t lvl, lvl_t ipl);
    return ien & pend & (lvl > ipl);
  endfunction

  // strict comparison keeps the earlier (lower) index on a tie
  function automatic logic outranks(lvl_t cand, lvl_t best);
    return cand > best;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctl(logic pend, lvl_t lvl);
    logic [DATA_W-1:0] r;
    r = '0;
    r[LVL_W-1:0] = lvl;
    r[FLAG_BIT] = pend;
    return r;
  endfunction
endpackage

// File: rtl/intc_ctl_reg.sv
module intc_ctl_reg
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hw_set,
  input  logic              ack_clr,
  output lvl_t              lvl,
  output logic              pend
);
  logic sw_clr;
  logic clr_evt;

  assign sw_clr  = wr_hit & ~wdata[FLAG_BIT];
  assign clr_evt = sw_clr | ack_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl  <= '0;
      pend <= 1'b0;
    end else begin
      if (wr_hit) lvl <= wdata[LVL_W-1:0];
      if (hw_set)       pend <= 1'b1;
      else if (clr_evt) pend <= 1'b0;
    end
  end

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> pend);
  assert_fall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> ($past(clr_evt) && !$past(hw_set)));
  assert_one_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wdata[FLAG_BIT] && !ack_clr && !hw_set) |=> (pend == $past(pend)));
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && !hw_set) |=> !pend);
  assert_level_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(lvl));
endmodule

// File: rtl/intc_bus_dec.sv
module intc_bus_dec
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int ADDR_W  = 8,
  parameter logic [NUM_SRC*ADDR_W-1:0] SRC_ADDR = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvls,
  input  logic [NUM_SRC-1:0]          pends,
  output logic [NUM_SRC-1:0]          wr_hit,
  output logic [DATA_W-1:0]           rdata
);
  logic [NUM_SRC-1:0] sel;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
    assign sel[i]    = (bus_addr == SRC_ADDR[i*ADDR_W +: ADDR_W]);
    assign wr_hit[i] = bus_wr & sel[i];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (sel[i]) rdata = rdata | pack_ctl(pends[i], lvls[i]);
  end

  assert_unique_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:FLAG_BIT+1] == '0);
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int ID_W    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ien,
  input  lvl_t                          ipl,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvls,
  input  logic [NUM_SRC-1:0]            pends,
  output logic                          req,
  output logic [ID_W-1:0]               id,
  output lvl_t                          lvl
);
  logic [NUM_SRC-1:0] elig;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig[i] = is_eligible(ien, pends[i], lvls[i], ipl);
  end

  always_comb begin
    lvl = '0;
    id  = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (elig[i] && outranks(lvls[i], lvl)) begin
        lvl = lvls[i];
        id  = ID_W'(i);
      end
  end

  assign req = |elig;

  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (ien && (lvl > ipl)));
  assert_grant_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (pends[id] && (lvls[id] == lvl)));
  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> ((id == '0) && (lvl == '0)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int ADDR_W  = 8,
  parameter logic [NUM_SRC*ADDR_W-1:0] SRC_ADDR =
    {8'h5C, 8'h5B, 8'h5A, 8'h59, 8'h58, 8'h56, 8'h52, 8'h51, 8'h50, 8'h4E, 8'h4D},
  localparam int ID_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic               int_en,
  input  logic [LVL_W-1:0]   cpu_ipl,
  input  logic               irq_ack,
  output logic               irq_req,
  output logic [ID_W-1:0]    irq_id,
  output logic [LVL_W-1:0]   irq_lvl
);
  logic [NUM_SRC-1:0][LVL_W-1:0] lvls;
  logic [NUM_SRC-1:0]            pends;
  logic [NUM_SRC-1:0]            wr_hit;
  logic [NUM_SRC-1:0]            ack_vec;

  intc_bus_dec #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .SRC_ADDR(SRC_ADDR)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .lvls(lvls), .pends(pends), .wr_hit(wr_hit), .rdata(bus_rdata)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign ack_vec[i] = irq_ack & irq_req & (irq_id == ID_W'(i));
    intc_ctl_reg u_reg (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit[i]), .wdata(bus_wdata),
      .hw_set(src_set[i]), .ack_clr(ack_vec[i]), .lvl(lvls[i]), .pend(pends[i])
    );
  end

  intc_arbiter #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .ien(int_en), .ipl(cpu_ipl),
    .lvls(lvls), .pends(pends), .req(irq_req), .id(irq_id), .lvl(irq_lvl)
  );

  assert_single_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_vec));
  assert_req_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> int_en);
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 11;
  localparam logic [7:0] MAP [N] = '{8'h4D, 8'h4E, 8'h50, 8'h51, 8'h52, 8'h56,
                                     8'h58, 8'h59, 8'h5A, 8'h5B, 8'h5C};

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_wr = 0, int_en = 0, irq_ack = 0, irq_req;
  logic [N-1:0] src_set = 0;
  logic [2:0] cpu_ipl = 0, irq_lvl;
  logic [3:0] irq_id;

  int total = 0, bad = 0;
  bit finished = 0;
  int lvl_m [N];
  bit flg_m [N];

  irq_prio_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int find_idx(logic [7:0] a);
    for (int i = 0; i < N; i++) if (MAP[i] == a) return i;
    return -1;
  endfunction

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    int k;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    k = find_idx(a);
    if (k >= 0) begin
      lvl_m[k] = d[2:0];
      if (!d[3]) flg_m[k] = 0;
    end
  endtask

  task automatic pulse_set(logic [N-1:0] m);
    @(negedge clk);
    src_set = m;
    @(negedge clk);
    src_set = 0;
    for (int i = 0; i < N; i++) if (m[i]) flg_m[i] = 1;
  endtask

  task automatic read_chk(string tag, logic [7:0] a, int exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic reg_chk_all(string tag);
    for (int i = 0; i < N; i++) read_chk(tag, MAP[i], flg_m[i] * 8 + lvl_m[i]);
  endtask

  // expected arbitration: walk levels top-down, first index at each level
  task automatic out_chk(string tag);
    int ew = -1, el = 0;
    #1;
    for (int l = 7; l >= 1 && ew < 0; l--)
      for (int i = 0; i < N && ew < 0; i++)
        if (int_en && flg_m[i] && lvl_m[i] == l && l > cpu_ipl) begin ew = i; el = l; end
    chk({tag, " req"}, irq_req, ew >= 0);
    chk({tag, " id (R10 when idle)"}, irq_id, ew >= 0 ? ew : 0);
    chk({tag, " lvl (R10 when idle)"}, irq_lvl, el);
  endtask

  task automatic t_reset;
    reg_chk_all("R1 reset readback");
    out_chk("R1 reset outputs");
  endtask

  task automatic t_fields;
    for (int i = 0; i < N; i++) bus_write(MAP[i], 8'hF8 | 8'((i % 7) + 1));
    reg_chk_all("R2 R9 level write, upper bits ignored");
    out_chk("R3 write of one does not set");
  endtask

  task automatic t_flag;
    pulse_set(N'(1) << 2);
    read_chk("R4 set pulse visible", MAP[2], 8 + lvl_m[2]);
    bus_write(MAP[2], 8'h08 | 8'(lvl_m[2]));
    read_chk("R3 write one keeps flag", MAP[2], 8 + lvl_m[2]);
    bus_write(MAP[2], 8'(lvl_m[2]));
    read_chk("R3 write zero clears flag", MAP[2], lvl_m[2]);
  endtask

  task automatic t_collide_sw;
    @(negedge clk);
    bus_addr = MAP[4]; bus_wdata = 8'h05; bus_wr = 1; src_set = N'(1) << 4;
    @(negedge clk);
    bus_wr = 0; src_set = 0;
    lvl_m[4] = 5; flg_m[4] = 1;
    read_chk("R5 set beats software clear", MAP[4], 8'h0D);
    bus_write(MAP[4], 8'h05);
    read_chk("R5 cleanup clear", MAP[4], 8'h05);
  endtask

  task automatic t_mask;
    bus_write(MAP[0], 8'h00);
    pulse_set(N'(1) << 0);
    int_en = 0;
    out_chk("R6 global enable low");
    int_en = 1;
    out_chk("R6 level zero never eligible");
    bus_write(MAP[6], 8'h03);
    pulse_set(N'(1) << 6);
    cpu_ipl = 3;
    out_chk("R6 level equal to ipl masked");
    cpu_ipl = 2;
    out_chk("R6 level above ipl accepted");
  endtask

  task automatic t_priority;
    bus_write(MAP[1], 8'h06);
    bus_write(MAP[9], 8'h06);
    bus_write(MAP[5], 8'h04);
    cpu_ipl = 0;
    pulse_set((N'(1) << 9) | (N'(1) << 5));
    out_chk("R7 highest level wins");
    pulse_set(N'(1) << 1);
    out_chk("R7 tie goes to lowest index");
    chk("R7 tie winner is source 1", irq_id, 1);
  endtask

  task automatic t_ack;
    int w;
    w = irq_id;
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    flg_m[w] = 0;
    reg_chk_all("R8 ack clears only winner");
    out_chk("R8 next winner after ack");
    w = irq_id;
    @(negedge clk); irq_ack = 1; src_set = N'(1) << w;
    @(negedge clk); irq_ack = 0; src_set = 0;
    read_chk("R5 R8 set beats ack clear", MAP[w], 8 + lvl_m[w]);
    out_chk("R8 winner kept after collision");
  endtask

  task automatic t_unmapped;
    bus_write(8'h4F, 8'h07);
    bus_write(8'h55, 8'h00);
    bus_write(8'h53, 8'h00);
    read_chk("R9 unmapped reads zero", 8'h4F, 0);
    read_chk("R9 unmapped 0x55 reads zero", 8'h55, 0);
    reg_chk_all("R9 unmapped writes ignored");
    out_chk("R9 outputs unchanged");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin lvl_m[i] = 0; flg_m[i] = 0; end
    #(CLK_PERIOD * 3);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_flag();
    t_collide_sw();
    t_mask();
    t_priority();
    t_ack();
    t_unmapped();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule